// File: doc/BRIEF.md
# Dual Serial-Port FIFO with Programmable Transmit Trigger

This block sits between a processor-side data path and the shift registers of a serial port. It holds two independent byte queues of sixteen entries each: one collects bytes waiting to be shifted out, and the other collects bytes that the receiver has assembled. A transmit-empty flag asks for more data once the transmit queue has drained to a level that software picks with a 2-bit code. The available levels are half, a quarter, an eighth of the depth, or completely empty.

A small control word sets the trigger code, a flush bit for each queue and a loopback switch. Software writes the word through a single-cycle write strobe and can read it back at any time. Each flush bit keeps its queue empty for as long as it is set. The loopback switch feeds the transmitter's serial output straight into the receiver's serial input, so a self-test can run without external wiring. During loopback the outgoing line is parked at the idle (mark) level.

Top module: `serial_fifo_trig`

## Requirements
- R1: Each queue returns bytes in the order they were accepted. An accepted pop loads the oldest byte into the queue's read-data register, and that byte is visible the cycle after the pop.
- R2: Each queue reports an occupancy from 0 to 16 on a 5-bit count. Full is 1 exactly when the count is 16, and empty is 1 exactly when the count is 0.
- R3: A push while the count is 16 is dropped. The count stays at 16 and the stored bytes are unchanged. A push and a pop in the same cycle on a full queue perform only the pop.
- R4: A pop while the count is 0 moves no pointer and leaves the read-data register holding its previous value. A push and a pop in the same cycle on an empty queue perform only the push.
- R5: Control bits [5:4] select the transmit threshold: 00 gives 8, 01 gives 4, 10 gives 2 and 11 gives 0. The transmit trigger output is 1 exactly when the transmit count is at or below the threshold. A new code applies from the cycle after its write.
- R6: While control bit 2 is 1, the transmit queue is forced empty on every clock and ignores pushes and pops. A push issued in the cycle after the bit is written back to 0 is accepted.
- R7: While control bit 1 is 1, the receive queue is forced empty on every clock and ignores pushes and pops. Normal operation resumes in the cycle after the bit is cleared.
- R8: When control bit 0 is 1, the receiver's serial input equals the transmitter's serial output. When bit 0 is 0, the receiver's serial input equals the external receive pin. Both paths are combinational.
- R9: When control bit 0 is 1, the external transmit pin is held at 1. Otherwise the pin follows the transmitter's serial output.
- R10: After reset, both counts are 0, both read-data registers are 0 and the control word reads 0.
- R11: Reading the control word returns the written bits [5:4], [2], [1] and [0] in place. Bits 3, 7 and 6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write value |
| cfg_rdata | output | 8 | Control word read value |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_wdata | input | 8 | Byte to push into the transmit queue |
| tx_full | output | 1 | Transmit queue holds 16 bytes |
| tx_pop | input | 1 | Transmitter takes the oldest byte |
| tx_rdata | output | 8 | Last byte popped from the transmit queue |
| tx_count | output | 5 | Transmit queue occupancy |
| tx_empty | output | 1 | Transmit queue holds no byte |
| tx_trig | output | 1 | Transmit occupancy at or below the selected threshold |
| rx_push | input | 1 | Receiver delivers a byte |
| rx_wdata | input | 8 | Byte delivered by the receiver |
| rx_full | output | 1 | Receive queue holds 16 bytes |
| rx_pop | input | 1 | Reader takes the oldest received byte |
| rx_rdata | output | 8 | Last byte popped from the receive queue |
| rx_count | output | 5 | Receive queue occupancy |
| rx_empty | output | 1 | Receive queue holds no byte |
| ser_txd_in | input | 1 | Serial bit stream from the transmit shifter |
| txd_pin | output | 1 | External transmit line |
| rxd_pin | input | 1 | External receive line |
| ser_rxd_out | output | 1 | Serial bit stream to the receive shifter |

## Verification
Counts, full and empty flags, and read data change on the first clock edge after a push or pop. The trigger output and the control readback reflect a control write right after the edge that captures it. The two serial routes follow their inputs within the same cycle. The bench changes inputs one time unit after a rising edge and compares the outputs one time unit after the following rising edge against a queue model that advances at that same edge. Serial routing is compared after the new line values have settled, before the next edge.

// File: rtl/sft_pkg.sv
package sft_pkg;

   typedef enum logic [1:0] {
      TRIG_HALF    = 2'b00,
      TRIG_QUARTER = 2'b01,
      TRIG_EIGHTH  = 2'b10,
      TRIG_DRAINED = 2'b11
   } trig_code_e;

   typedef struct packed {
      trig_code_e trig;
      logic       tx_flush;
      logic       rx_flush;
      logic       loop_en;
   } ctrl_t;

   // bit positions in the control word
   localparam int unsigned CW_TRIG_LSB = 4;
   localparam int unsigned CW_TXF_BIT  = 2;
   localparam int unsigned CW_RXF_BIT  = 1;
   localparam int unsigned CW_LOOP_BIT = 0;
   localparam int unsigned CW_MIN_W    = 6;

   function automatic int unsigned trig_level(trig_code_e code, int unsigned depth);
      case (code)
         TRIG_HALF:    return depth / 2;
         TRIG_QUARTER: return depth / 4;
         TRIG_EIGHTH:  return depth / 8;
         default:      return 0;
      endcase
   endfunction

endpackage

// File: rtl/sft_ctrl_regs.sv
module sft_ctrl_regs
   import sft_pkg::*;
#(
   parameter int unsigned CFG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output ctrl_t            ctrl,
   output logic [CFG_W-1:0] rdata
);

   initial begin
      assert (CFG_W >= CW_MIN_W)
         else $error("sft_ctrl_regs: CFG_W must be at least %0d", CW_MIN_W);
   end

   ctrl_t ctrl_q;
   logic  unused_wbits;

   assign unused_wbits = ^{wdata[CFG_W-1:CW_TRIG_LSB+2], wdata[CW_TXF_BIT+1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (we) begin
         ctrl_q.trig     <= trig_code_e'(wdata[CW_TRIG_LSB +: 2]);
         ctrl_q.tx_flush <= wdata[CW_TXF_BIT];
         ctrl_q.rx_flush <= wdata[CW_RXF_BIT];
         ctrl_q.loop_en  <= wdata[CW_LOOP_BIT];
      end
   end

   always_comb begin
      rdata                      = '0;
      rdata[CW_TRIG_LSB +: 2]    = ctrl_q.trig;
      rdata[CW_TXF_BIT]          = ctrl_q.tx_flush;
      rdata[CW_RXF_BIT]          = ctrl_q.rx_flush;
      rdata[CW_LOOP_BIT]         = ctrl_q.loop_en;
   end

   assign ctrl = ctrl_q;

endmodule

// File: rtl/sft_fifo.sv
module sft_fifo #(
   parameter  int unsigned DATA_W = 8,
   parameter  int unsigned DEPTH  = 16,
   localparam int unsigned AW     = $clog2(DEPTH),
   localparam int unsigned CW     = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] rdata,
   output logic [CW-1:0]     count,
   output logic              full,
   output logic              empty
);

   initial begin
      assert (DEPTH >= 8 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("sft_fifo: DEPTH must be a power of two of at least 8");
      assert (DATA_W >= 1)
         else $error("sft_fifo: DATA_W must be positive");
   end

   localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr;
   logic [AW-1:0]     rd_ptr;
   logic [CW-1:0]     cnt_q;
   logic [DATA_W-1:0] rdata_q;
   logic              push_ok;
   logic              pop_ok;
   logic [CW-1:0]     cnt_inc;
   logic [CW-1:0]     cnt_dec;

   assign full    = (cnt_q == CNT_FULL);
   assign empty   = (cnt_q == '0);
   assign push_ok = push & ~flush & ~full;
   assign pop_ok  = pop  & ~flush & ~empty;
   assign cnt_inc = {{(CW-1){1'b0}}, push_ok};
   assign cnt_dec = {{(CW-1){1'b0}}, pop_ok};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         cnt_q   <= '0;
         rdata_q <= '0;
      end else if (flush) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         cnt_q   <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok) begin
            rd_ptr  <= rd_ptr + 1'b1;
            rdata_q <= mem[rd_ptr];
         end
         cnt_q <= cnt_q + cnt_inc - cnt_dec;
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   assign rdata = rdata_q;
   assign count = cnt_q;

endmodule

// File: rtl/sft_trig_cmp.sv
module sft_trig_cmp
   import sft_pkg::*;
#(
   parameter  int unsigned DEPTH = 16,
   localparam int unsigned CW    = $clog2(DEPTH) + 1
) (
   input  trig_code_e    code,
   input  logic [CW-1:0] count,
   output logic          flag
);

   localparam logic [CW-1:0] LVL_HALF    = CW'(trig_level(TRIG_HALF,    DEPTH));
   localparam logic [CW-1:0] LVL_QUARTER = CW'(trig_level(TRIG_QUARTER, DEPTH));
   localparam logic [CW-1:0] LVL_EIGHTH  = CW'(trig_level(TRIG_EIGHTH,  DEPTH));
   localparam logic [CW-1:0] LVL_DRAINED = CW'(trig_level(TRIG_DRAINED, DEPTH));

   logic [CW-1:0] level;

   always_comb begin
      case (code)
         TRIG_HALF:    level = LVL_HALF;
         TRIG_QUARTER: level = LVL_QUARTER;
         TRIG_EIGHTH:  level = LVL_EIGHTH;
         default:      level = LVL_DRAINED;
      endcase
   end

   assign flag = (count <= level);

endmodule

// File: rtl/sft_loop_mux.sv
module sft_loop_mux #(
   parameter bit MUTE_TX = 1'b1
) (
   input  logic loop_en,
   input  logic ser_txd_in,
   input  logic rxd_pin,
   output logic txd_pin,
   output logic ser_rxd_out
);

   assign ser_rxd_out = loop_en ? ser_txd_in : rxd_pin;

   generate
      if (MUTE_TX) begin : g_mute
         assign txd_pin = loop_en ? 1'b1 : ser_txd_in;
      end else begin : g_mirror
         assign txd_pin = ser_txd_in;
      end
   endgenerate

endmodule

// File: rtl/serial_fifo_trig.sv
module serial_fifo_trig
   import sft_pkg::*;
#(
   parameter  int unsigned DATA_W  = 8,
   parameter  int unsigned DEPTH   = 16,
   parameter  int unsigned CFG_W   = 8,
   parameter  bit          MUTE_TX = 1'b1,
   localparam int unsigned CW      = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic              tx_push,
   input  logic [DATA_W-1:0] tx_wdata,
   output logic              tx_full,
   input  logic              tx_pop,
   output logic [DATA_W-1:0] tx_rdata,
   output logic [CW-1:0]     tx_count,
   output logic              tx_empty,
   output logic              tx_trig,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_wdata,
   output logic              rx_full,
   input  logic              rx_pop,
   output logic [DATA_W-1:0] rx_rdata,
   output logic [CW-1:0]     rx_count,
   output logic              rx_empty,
   input  logic              ser_txd_in,
   output logic              txd_pin,
   input  logic              rxd_pin,
   output logic              ser_rxd_out
);

   ctrl_t ctrl;
   logic  tx_flush_w;
   logic  rx_flush_w;
   logic  loop_en_w;

   assign tx_flush_w = ctrl.tx_flush;
   assign rx_flush_w = ctrl.rx_flush;
   assign loop_en_w  = ctrl.loop_en;

   sft_ctrl_regs #(.CFG_W(CFG_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .ctrl  (ctrl),
      .rdata (cfg_rdata)
   );

   sft_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (tx_flush_w),
      .push  (tx_push),
      .wdata (tx_wdata),
      .pop   (tx_pop),
      .rdata (tx_rdata),
      .count (tx_count),
      .full  (tx_full),
      .empty (tx_empty)
   );

   sft_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (rx_flush_w),
      .push  (rx_push),
      .wdata (rx_wdata),
      .pop   (rx_pop),
      .rdata (rx_rdata),
      .count (rx_count),
      .full  (rx_full),
      .empty (rx_empty)
   );

   sft_trig_cmp #(.DEPTH(DEPTH)) u_trig (
      .code  (ctrl.trig),
      .count (tx_count),
      .flag  (tx_trig)
   );

   sft_loop_mux #(.MUTE_TX(MUTE_TX)) u_loop (
      .loop_en     (loop_en_w),
      .ser_txd_in  (ser_txd_in),
      .rxd_pin     (rxd_pin),
      .txd_pin     (txd_pin),
      .ser_rxd_out (ser_rxd_out)
   );

endmodule

// File: rtl/sft_checker.sv
module sft_checker #(
   parameter  int unsigned DEPTH   = 16,
   parameter  int unsigned DATA_W  = 8,
   parameter  int unsigned CFG_W   = 8,
   parameter  bit          MUTE_TX = 1'b1,
   localparam int unsigned CW      = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CW-1:0]     tx_count,
   input logic [CW-1:0]     rx_count,
   input logic              tx_push,
   input logic              tx_pop,
   input logic [DATA_W-1:0] tx_rdata,
   input logic              tx_trig,
   input logic              tx_flush,
   input logic              rx_flush,
   input logic              loop_en,
   input logic              ser_txd_in,
   input logic              rxd_pin,
   input logic              txd_pin,
   input logic              ser_rxd_out,
   input logic [CFG_W-1:0]  cfg_rdata
);

   localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
   localparam logic [CW-1:0] CNT_HALF = CW'(DEPTH / 2);

   p_count_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_count <= CNT_FULL && rx_count <= CNT_FULL);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_count == CNT_FULL && tx_push && !tx_pop && !tx_flush) |=> tx_count == CNT_FULL);

   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_count == '0 && tx_pop && !tx_push) |=> (tx_count == '0 && $stable(tx_rdata)));

   p_trig_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_count == '0 |-> tx_trig);

   p_trig_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_count > CNT_HALF |-> !tx_trig);

   p_tx_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_flush |=> tx_count == '0);

   p_rx_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flush |=> rx_count == '0);

   p_loop_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
      loop_en |-> ser_rxd_out == ser_txd_in);

   p_pin_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !loop_en |-> ser_rxd_out == rxd_pin);

   generate
      if (MUTE_TX) begin : g_mute_chk
         p_tx_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
            loop_en |-> txd_pin);
      end
   endgenerate

   p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[3] == 1'b0 && cfg_rdata[CFG_W-1:6] == '0);

endmodule

bind serial_fifo_trig sft_checker #(
   .DEPTH(DEPTH), .DATA_W(DATA_W), .CFG_W(CFG_W), .MUTE_TX(MUTE_TX)
) u_sft_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_count    (tx_count),
   .rx_count    (rx_count),
   .tx_push     (tx_push),
   .tx_pop      (tx_pop),
   .tx_rdata    (tx_rdata),
   .tx_trig     (tx_trig),
   .tx_flush    (tx_flush_w),
   .rx_flush    (rx_flush_w),
   .loop_en     (loop_en_w),
   .ser_txd_in  (ser_txd_in),
   .rxd_pin     (rxd_pin),
   .txd_pin     (txd_pin),
   .ser_rxd_out (ser_rxd_out),
   .cfg_rdata   (cfg_rdata)
);

// File: tb/serial_fifo_trig_tb.sv
module serial_fifo_trig_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;
   localparam int N_RANDOM   = 4000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
   logic [7:0] tx_wdata = '0, rx_wdata = '0;
   logic [7:0] tx_rdata, rx_rdata;
   logic [4:0] tx_count, rx_count;
   logic       tx_full, tx_empty, tx_trig, rx_full, rx_empty;
   logic       ser_txd_in = 1'b1, rxd_pin = 1'b1;
   logic       txd_pin, ser_rxd_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // bench model
   logic [7:0] q_tx[$];
   logic [7:0] q_rx[$];
   logic [7:0] m_tx_rd = '0, m_rx_rd = '0;
   logic [1:0] m_trig = '0;
   logic       m_txf = 1'b0, m_rxf = 1'b0, m_loop = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_fifo_trig u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_full(tx_full), .tx_pop(tx_pop),
      .tx_rdata(tx_rdata), .tx_count(tx_count), .tx_empty(tx_empty), .tx_trig(tx_trig),
      .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_full(rx_full), .rx_pop(rx_pop),
      .rx_rdata(rx_rdata), .rx_count(rx_count), .rx_empty(rx_empty),
      .ser_txd_in(ser_txd_in), .txd_pin(txd_pin), .rxd_pin(rxd_pin), .ser_rxd_out(ser_rxd_out)
   );

   function automatic int thr(logic [1:0] code);
      case (code)
         2'b00:   return 8;
         2'b01:   return 4;
         2'b10:   return 2;
         default: return 0;
      endcase
   endfunction

   function automatic logic [7:0] exp_cfg();
      return {2'b00, m_trig, 1'b0, m_txf, m_rxf, m_loop};
   endfunction

   task automatic chk(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // advance the model by one clock edge, using the inputs held across it
   task automatic model_edge();
      int  tc = q_tx.size();
      int  rc = q_rx.size();
      bit  tpu = tx_push && !m_txf && tc < DEPTH;
      bit  tpo = tx_pop  && !m_txf && tc > 0;
      bit  rpu = rx_push && !m_rxf && rc < DEPTH;
      bit  rpo = rx_pop  && !m_rxf && rc > 0;
      if (m_txf) q_tx.delete();
      else begin
         if (tpo) m_tx_rd = q_tx.pop_front();
         if (tpu) q_tx.push_back(tx_wdata);
      end
      if (m_rxf) q_rx.delete();
      else begin
         if (rpo) m_rx_rd = q_rx.pop_front();
         if (rpu) q_rx.push_back(rx_wdata);
      end
      if (cfg_we) begin
         m_trig = cfg_wdata[5:4];
         m_txf  = cfg_wdata[2];
         m_rxf  = cfg_wdata[1];
         m_loop = cfg_wdata[0];
      end
   endtask

   task automatic compare();
      chk("R2 tx_count", int'(tx_count), q_tx.size());
      chk("R2 rx_count", int'(rx_count), q_rx.size());
      chk("R2 tx_full",  int'(tx_full),  int'(q_tx.size() == DEPTH));
      chk("R2 tx_empty", int'(tx_empty), int'(q_tx.size() == 0));
      chk("R2 rx_full",  int'(rx_full),  int'(q_rx.size() == DEPTH));
      chk("R2 rx_empty", int'(rx_empty), int'(q_rx.size() == 0));
      chk("R1 tx_rdata", int'(tx_rdata), int'(m_tx_rd));
      chk("R1 rx_rdata", int'(rx_rdata), int'(m_rx_rd));
      chk("R5 tx_trig",  int'(tx_trig),  int'(q_tx.size() <= thr(m_trig)));
      chk("R11 cfg_rdata", int'(cfg_rdata), int'(exp_cfg()));
   endtask

   task automatic serial_check();
      chk("R8 ser_rxd_out", int'(ser_rxd_out), int'(m_loop ? ser_txd_in : rxd_pin));
      chk("R9 txd_pin",     int'(txd_pin),     int'(m_loop ? 1'b1 : ser_txd_in));
   endtask

   task automatic tick();
      @(posedge clk);
      model_edge();
      #1;
      compare();
   endtask

   task automatic idle_inputs();
      cfg_we = 1'b0; tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
   endtask

   task automatic write_cfg(logic [7:0] v);
      cfg_we = 1'b1; cfg_wdata = v;
      tick();
      cfg_we = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1F0C_5A17));
      repeat (3) @(posedge clk);
      #1;
      // R10: reset state
      chk("R10 tx_count", int'(tx_count), 0);
      chk("R10 rx_count", int'(rx_count), 0);
      chk("R10 cfg_rdata", int'(cfg_rdata), 0);
      chk("R10 tx_rdata", int'(tx_rdata), 0);
      chk("R10 rx_rdata", int'(rx_rdata), 0);
      rst_n = 1'b1;
      tick();

      // R5: drained code, then overfill transmit (R3)
      write_cfg(8'h30);
      chk("R5 trig at empty code 11", int'(tx_trig), 1);
      for (int i = 0; i < DEPTH + 3; i++) begin
         tx_push = 1'b1; tx_wdata = 8'(8'hA0 + i);
         tick();
      end
      chk("R3 count stays full", int'(tx_count), DEPTH);
      tx_pop = 1'b1; tx_wdata = 8'hEE;
      tick();
      chk("R3 push+pop on full pops only", int'(tx_count), DEPTH - 1);
      chk("R3 oldest byte kept", int'(tx_rdata), 8'hA0);
      tx_push = 1'b0;
      // sweep trigger codes at several levels while draining
      for (int i = 0; i < DEPTH + 2; i++) begin
         tx_pop = 1'b1;
         tick();
         tx_pop = 1'b0;
         for (int c = 0; c < 4; c++) write_cfg(8'(c << 4));
      end
      chk("R4 underflow count", int'(tx_count), 0);
      chk("R4 rdata holds last byte", int'(tx_rdata), 8'hAF);
      tx_push = 1'b1; tx_pop = 1'b1; tx_wdata = 8'h5C;
      tick();
      idle_inputs();
      chk("R4 push+pop on empty pushes only", int'(tx_count), 1);
      chk("R4 rdata unchanged", int'(tx_rdata), 8'hAF);

      // R7: receive flush
      for (int i = 0; i < 5; i++) begin
         rx_push = 1'b1; rx_wdata = 8'(8'h30 + i);
         tick();
      end
      rx_push = 1'b0;
      write_cfg(8'h02);
      tick();
      chk("R7 rx flushed", int'(rx_count), 0);
      rx_push = 1'b1; rx_wdata = 8'h77;
      tick();
      chk("R7 push ignored during flush", int'(rx_count), 0);
      rx_push = 1'b0;
      write_cfg(8'h00);
      rx_push = 1'b1; rx_wdata = 8'h78;
      tick();
      rx_push = 1'b0;
      chk("R7 push accepted after clear", int'(rx_count), 1);

      // R6: transmit flush
      tx_push = 1'b1; tx_wdata = 8'h11;
      tick();
      tx_push = 1'b0;
      write_cfg(8'h04);
      tx_push = 1'b1;
      tick();
      chk("R6 tx flushed and push ignored", int'(tx_count), 0);
      tx_push = 1'b0;
      write_cfg(8'h00);
      tx_push = 1'b1; tx_wdata = 8'h12;
      tick();
      tx_push = 1'b0;
      chk("R6 push accepted cycle after clear", int'(tx_count), 1);

      // R8/R9: serial routing in both modes
      for (int m = 0; m < 2; m++) begin
         write_cfg(8'(m));
         for (int v = 0; v < 4; v++) begin
            ser_txd_in = v[0]; rxd_pin = v[1];
            #1;
            serial_check();
         end
      end
      // R11: reserved bits written as 1
      write_cfg(8'hFF);
      chk("R11 reserved bits read 0", int'(cfg_rdata), 8'h37);
      write_cfg(8'h00);

      // constrained random phase
      for (int i = 0; i < N_RANDOM; i++) begin
         int bias = (i / 250) % 4;
         tx_push  = ($urandom % 4) < (bias + 1);
         tx_pop   = ($urandom % 4) >= (bias + 1) || ($urandom % 8 == 0);
         rx_push  = ($urandom % 4) < (3 - bias + 1);
         rx_pop   = ($urandom % 3) == 0;
         tx_wdata = 8'($urandom);
         rx_wdata = 8'($urandom);
         cfg_we   = ($urandom % 16) == 0;
         cfg_wdata = 8'($urandom);
         if ($urandom % 6 != 0) cfg_wdata[2:1] = 2'b00;
         ser_txd_in = 1'($urandom);
         rxd_pin    = 1'($urandom);
         tick();
         serial_check();
      end
      idle_inputs();
      tick();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule